// File: doc/BRIEF.md
# Signed Partial Product Generator

This block forms every partial-product bit for an N x N two's-complement multiply, laid out so that a later adder array can sum the bits directly with no sign-extension rows. The terms that the sign-handling scheme needs in complemented form are produced already complemented. These are the products of one operand's sign bit with the other operand's non-sign bits. The product of the two sign bits and every term without a sign bit come out in true form.

The array is built only from reversible, parity-preserving cells. Most cells take four inputs and two tie values. Setting the second tie to 1 makes the cell emit a complemented product, and leaving it at 0 gives a true product. The other cells are three-input controlled-swap cells, which are used where a cell has only one operand bit to hand on. No wire drives more than one cell input. Each operand bit reaches the cells in its row or column by being passed along a chain of cells. The x chains run from the bottom row up, and the y chains run from the last column towards column 0.

Because every cell preserves parity, the XOR of all outputs must equal the XOR of all inputs and tie values. A flag compares the two sides. A per-cell fault input flips one cell's internal product so that the detector can be exercised.

Top module: `ppgen_array`

## Requirements
- R1: For every position (i, j) that is not complemented, `term[i][j]` equals `op_x[j] & op_y[i]`.
- R2: For i = N-1 and j < N-1, `term[i][j]` equals `~(op_x[j] & op_y[i])`.
- R3: For j = N-1 and i < N-1, `term[i][j]` equals `~(op_x[j] & op_y[i])`.
- R4: `term[N-1][N-1]` equals `op_x[N-1] & op_y[N-1]` and is not complemented.
- R5: With `fault_inj` all zero, `parity_err` is 0 for every pair of operands.
- R6: Bit i*N+j of `fault_inj` flips the AND result inside cell (i, j). At a true-form position the term is inverted. At a complemented position the term is unchanged and only spill slot 0 of that cell changes. Any odd number of set bits drives `parity_err` to 1.
- R7: The XOR of all bits of `op_x`, `op_y`, `term` and `spill` equals the XOR of the bits of `fault_inj`. The tie values have even parity in total.
- R8: Any even number of set bits in `fault_inj` leaves `parity_err` at 0.
- R9: Spill slot 1 is 0 for every cell with i > 0, and spill slot 2 is 0 for every cell with j > 0. `spill[0][0][1]` carries `op_x[0]`, and `spill[N-1][0][2]` carries `op_y[N-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | N | Multiplicand, two's complement |
| op_y | input | N | Multiplier, two's complement |
| fault_inj | input | N*N | Per-cell upset injection, bit i*N+j targets cell (i, j) |
| term | output | N*N | Partial-product bits, packed as [row i][column j] |
| spill | output | N*N*3 | Unused cell outputs, three slots per cell; a slot with no signal reads 0 |
| parity_err | output | 1 | High when input-side and output-side parity disagree |

## Verification
The hardest case to reach is a fault that produces no visible symptom. A flip inside a complemented-position cell leaves every term intact and shows up only in that cell's spill slot. A pair of flips cancels in the parity and escapes the flag. To reach these cases, the stimulus sweeps a single set bit through all sixteen cells under several operand patterns, so that both kinds of cell are hit. It then sets adjacent pairs and triples of bits, and it checks the terms, the spill parity and the flag against a reference computed from the operand values.

// File: rtl/ppgen_pkg.sv
package ppgen_pkg;

  typedef enum logic {
    CELL_DUAL = 1'b0,
    CELL_SWAP = 1'b1
  } cell_kind_e;

  // complemented positions: exactly one of the two indices is the sign index
  function automatic logic is_inv(input int i, input int j, input int n);
    return logic'((i == n-1) != (j == n-1));
  endfunction

  // interior cells hand on both bits; complemented cells need both tie inputs
  function automatic cell_kind_e kind_of(input int i, input int j, input int n);
    if ((i > 0 && j > 0) || is_inv(i, j, n)) return CELL_DUAL;
    return CELL_SWAP;
  endfunction

endpackage

// File: rtl/ppgen_dual_cell.sv
module ppgen_dual_cell (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic flt,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  logic prod;

  always_comb begin
    prod = a & b;
    p    = a;
    q    = b;
    r    = prod ^ c ^ flt;
    s    = prod ^ d;
    if (!flt) begin
      // R7: cell keeps input parity
      assert_cell_parity_R7: assert ((a ^ b ^ c ^ d) == (p ^ q ^ r ^ s))
        else $error("dual cell parity lost");
      // R1: ties are recoverable from the outputs (reversibility)
      assert_dual_inverse_R1: assert ((r ^ (p & q)) == c && (s ^ (p & q)) == d)
        else $error("dual cell not invertible");
    end
  end
endmodule

// File: rtl/ppgen_swap_cell.sv
module ppgen_swap_cell (
  input  logic ctl,
  input  logic dat,
  input  logic zer,
  input  logic flt,
  output logic p,
  output logic q,
  output logic r
);
  logic r_raw;

  always_comb begin
    p     = ctl;
    q     = ctl ? zer : dat;
    r_raw = ctl ? dat : zer;
    r     = r_raw ^ flt;
    if (!flt) begin
      // R1: the same swap applied to the outputs restores the inputs
      assert_swap_inverse_R1: assert (dat == (p ? r : q) && zer == (p ? q : r))
        else $error("swap cell not invertible");
    end
  end
endmodule

// File: rtl/ppgen_array.sv
module ppgen_array #(
  parameter int N = 4
) (
  input  logic [N-1:0]                 op_x,
  input  logic [N-1:0]                 op_y,
  input  logic [N*N-1:0]               fault_inj,
  output logic [N-1:0][N-1:0]          term,
  output logic [N-1:0][N-1:0][2:0]     spill,
  output logic                         parity_err
);
  import ppgen_pkg::*;

  localparam int  TIE_ONES = 2 * (N - 1);
  localparam logic TIE_PAR = logic'(TIE_ONES % 2);

  logic [N-1:0][N-1:0] xin, yin, xout, yout, spare;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam logic INV = is_inv(i, j, N);

      // x chains climb from row N-1 to row 0; y chains run from column N-1 to 0
      if (i == N-1) begin : g_xsrc
        assign xin[i][j] = op_x[j];
      end else begin : g_xlnk
        assign xin[i][j] = xout[i+1][j];
      end
      if (j == N-1) begin : g_ysrc
        assign yin[i][j] = op_y[i];
      end else begin : g_ylnk
        assign yin[i][j] = yout[i][j+1];
      end

      if (kind_of(i, j, N) == CELL_DUAL) begin : g_dual
        logic r_o, s_o;
        ppgen_dual_cell u_cell (
          .a(xin[i][j]), .b(yin[i][j]), .c(1'b0), .d(INV),
          .flt(fault_inj[i*N+j]),
          .p(xout[i][j]), .q(yout[i][j]), .r(r_o), .s(s_o)
        );
        assign term[i][j]  = INV ? s_o : r_o;
        assign spare[i][j] = INV ? r_o : s_o;
      end else if (i == 0 && j > 0) begin : g_swy
        logic p_o;
        ppgen_swap_cell u_cell (
          .ctl(yin[i][j]), .dat(xin[i][j]), .zer(1'b0),
          .flt(fault_inj[i*N+j]),
          .p(p_o), .q(spare[i][j]), .r(term[i][j])
        );
        assign yout[i][j] = p_o;
        assign xout[i][j] = 1'b0;
      end else begin : g_swx
        logic p_o;
        ppgen_swap_cell u_cell (
          .ctl(xin[i][j]), .dat(yin[i][j]), .zer(1'b0),
          .flt(fault_inj[i*N+j]),
          .p(p_o), .q(spare[i][j]), .r(term[i][j])
        );
        assign xout[i][j] = p_o;
        assign yout[i][j] = 1'b0;
      end

      // slot 0: spare product output; slots 1/2: bits leaving the chains
      assign spill[i][j][0] = spare[i][j];
      assign spill[i][j][1] = (i == 0) ? xout[i][j] : 1'b0;
      assign spill[i][j][2] = (j == 0) ? yout[i][j] : 1'b0;
    end
  end

  logic par_in, par_out;

  always_comb begin
    par_in     = (^op_x) ^ (^op_y) ^ TIE_PAR;
    par_out    = (^term) ^ (^spill);
    parity_err = par_in ^ par_out;
    if (fault_inj == '0) begin
      assert_clean_flag_R5: assert (!parity_err)
        else $error("parity flag raised with no fault");
    end
    if ($countones(fault_inj) == 1) begin
      assert_single_fault_R6: assert (parity_err)
        else $error("single fault not flagged");
    end
  end
endmodule

// File: tb/ppgen_array_test.sv
module ppgen_array_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]             op_x, op_y;
  logic [N*N-1:0]           fault_inj;
  logic [N-1:0][N-1:0]      term;
  logic [N-1:0][N-1:0][2:0] spill;
  logic                     parity_err;

  int checks = 0;
  int errors = 0;

  ppgen_array #(.N(N)) uut (
    .op_x(op_x), .op_y(op_y), .fault_inj(fault_inj),
    .term(term), .spill(spill), .parity_err(parity_err)
  );

  function automatic bit inv_pos(int i, int j);
    return (i == N-1) != (j == N-1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d x=%0h y=%0h f=%0h",
               tag, act, exp, op_x, op_y, fault_inj);
    end
  endtask

  // reference model evaluated each applied cycle
  task automatic verify();
    int fpar;
    int obits;
    fpar = $countones(fault_inj) % 2;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        int e;
        bit f;
        f = fault_inj[i*N+j];
        e = (op_x[j] & op_y[i]) ? 1 : 0;
        if (inv_pos(i, j)) e = 1 - e;
        else if (f) e = 1 - e;
        if (i == N-1 && j == N-1)  chk("R4 sign corner", int'(term[i][j]), e);
        else if (i == N-1)         chk("R2 sign row",    int'(term[i][j]), e);
        else if (j == N-1)         chk("R3 sign column", int'(term[i][j]), e);
        else if (f)                chk("R6 faulted term", int'(term[i][j]), e);
        else                       chk("R1 plain term",  int'(term[i][j]), e);
        if (i > 0) chk("R9 slot1 idle", int'(spill[i][j][1]), 0);
        if (j > 0) chk("R9 slot2 idle", int'(spill[i][j][2]), 0);
      end
    end
    chk("R9 x0 exit", int'(spill[0][0][1]), int'(op_x[0]));
    chk("R9 ysign exit", int'(spill[N-1][0][2]), int'(op_y[N-1]));
    obits = int'((^op_x) ^ (^op_y) ^ (^term) ^ (^spill));
    chk("R7 parity balance", obits, fpar);
    if (fault_inj == '0)  chk("R5 clean flag", int'(parity_err), 0);
    else if (fpar == 1)   chk("R6 odd faults flagged", int'(parity_err), 1);
    else                  chk("R8 even faults hidden", int'(parity_err), 0);
  endtask

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y,
                       input logic [N*N-1:0] f);
    @(posedge clk);
    op_x = x;
    op_y = y;
    fault_inj = f;
    @(negedge clk);
    verify();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    op_x = '0;
    op_y = '0;
    fault_inj = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    verify();  // state after reset: zero operands, no fault

    // R1..R5, R7, R9: all operand pairs, fault-free
    for (int v = 0; v < 256; v++) begin
      apply(v[3:0], v[7:4], '0);
    end

    // R6: single fault through every cell, several operand patterns
    for (int c = 0; c < N*N; c++) begin
      apply(4'hF, 4'hF, 16'(1) << c);
      apply(4'hA, 4'h5, 16'(1) << c);
      apply(4'h0, 4'h0, 16'(1) << c);
      apply(4'h6, 4'hB, 16'(1) << c);
    end

    // R8: adjacent fault pairs
    for (int c = 0; c < N*N-1; c++) begin
      apply(4'h9, 4'h7, (16'(3)) << c);
    end

    // R6: triples stay odd
    for (int c = 0; c < N*N-2; c += 3) begin
      apply(4'hC, 4'h3, (16'(7)) << c);
    end

    // R8: all cells faulted at once (even count)
    apply(4'h5, 4'hE, '1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule